// File: doc/BRIEF.md
# Two-Wire Slave Control Register Port

This block lets a two-wire bus master read and write a bank of byte-wide control registers held inside it. SCL and SDA reach it already synchronized to the system clock. The block finds bus conditions by comparing each sample with the one taken a clock earlier. It shifts in bytes on rising SCL and places its own SDA bits after falling SCL. SDA is open-drain: the block drives one enable that pulls the line low and never drives it high.

A transaction opens with a device byte. Its upper six address bits are fixed by a parameter, and the seventh comes from a strap pin, so two blocks can share one bus. In a write, the next byte loads an internal register pointer, and every byte after that is stored at the pointer, which then advances. A read, often reached through a repeated start after a pointer write, streams registers out from the pointer. The pointer stops at the top register and never wraps. Local logic sees every register through a combinational read port. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure: the bus master sets the pace alone.

Top module: `twi_regport`

## Requirements
- R1: SDA falling while SCL is high is a start, and SDA rising while SCL is high is a stop. A stop releases SDA and makes the block deaf to every bit until the next start, so a byte clocked after a stop with no start gets no acknowledge.
- R2: The device byte is seven address bits, MSB first, followed by a direction bit (1 = read, 0 = write). Its address is 0x4C when the strap is 0 and 0x4D when the strap is 1. On a match the block pulls SDA low during the ninth SCL pulse.
- R3: If the device byte does not match, the block gives no acknowledge, writes no register and ignores the bus until the next start.
- R4: In a write, the byte after the device byte becomes the pointer. Each later byte is written to the register at the pointer and acknowledged, and the pointer then advances by one.
- R5: The pointer saturates at the top register (0x19 with the default 26 registers). Further bytes in the same write all land in register 0x19.
- R6: A pointer byte above the top register is not acknowledged. It changes no register, and the data bytes that follow it get no acknowledge.
- R7: A read returns bytes MSB first, starting at the pointer left by the last write, and the pointer advances after each byte. Once the pointer reaches 0x19, register 0x19 is returned again and again.
- R8: When the master leaves a read byte unacknowledged, the block releases SDA and sends nothing more until a start.
- R9: A repeated start opens a new device byte and keeps the pointer, so a pointer write followed by a read works without a stop.
- R10: The block changes its SDA pull-low output only while SCL is low.
- R11: After reset every register reads 0x00 and the pointer is 0x00.
- R12: The local read port returns, for any index, the current content of that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized serial clock |
| sda_i | input | 1 | Synchronized serial data as seen on the wire |
| sda_pull_low_o | output | 1 | 1 pulls SDA low; 0 leaves it released |
| addr_strap_i | input | 1 | Least significant bit of the device address |
| host_raddr_i | input | ADDR_W (5) | Register index for the local read port |
| host_rdata_o | output | 8 | Content of the register at host_raddr_i |

## Verification
The bench builds the block with its default 26 registers, so the top register is 0x19. Short bursts starting at 0x17 or 0x18 therefore reach saturation on both the write and the read path, and a pointer byte of 0x1A is a legal way to test the refusal. The strap is driven to both values, so both device addresses, and a mismatch against each, are exercised. Random bursts with a fixed seed then follow, each a pointer write and then a repeated-start read-back.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CW = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVADDR,
    ST_REGADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } twi_state_e;
endpackage

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // SDA moving while SCL stays high is a bus condition, never data
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank #(
  parameter int NUM_REGS = 26,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_a_i,
  output logic [DATA_W-1:0] rd_data_a_o,
  input  logic [ADDR_W-1:0] rd_addr_b_i,
  output logic [DATA_W-1:0] rd_data_b_o
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_en_i && int'(wr_addr_i) == g)
        regs[g] <= wr_data_i;
    end
  end

  assign rd_data_a_o = (int'(rd_addr_a_i) < NUM_REGS) ? regs[rd_addr_a_i] : '0;
  assign rd_data_b_o = (int'(rd_addr_b_i) < NUM_REGS) ? regs[rd_addr_b_i] : '0;
endmodule

// File: rtl/twi_slave_engine.sv
module twi_slave_engine
  import twi_pkg::*;
#(
  parameter int          TOP_REG = 25,
  parameter int          ADDR_W  = 5,
  parameter logic [5:0]  DEV_HI  = 6'b100110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic              strap_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_low_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [ADDR_W-1:0] ptr_o
);
  twi_state_e        state, after_ack;
  logic [BIT_CW-1:0] cnt;
  logic              full, more;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-2:0] tx;
  logic [ADDR_W-1:0] ptr;

  function automatic logic [ADDR_W-1:0] sat_inc(input logic [ADDR_W-1:0] p);
    return (p == ADDR_W'(TOP_REG)) ? p : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      after_ack <= ST_IDLE;
      cnt       <= '0;
      full      <= 1'b0;
      more      <= 1'b0;
      sh        <= '0;
      tx        <= '0;
      ptr       <= '0;
      sda_low_o <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        state     <= ST_DEVADDR;
        cnt       <= '0;
        full      <= 1'b0;
        sda_low_o <= 1'b0;
      end else if (stop_i) begin
        state     <= ST_IDLE;
        full      <= 1'b0;
        sda_low_o <= 1'b0;
      end else begin
        case (state)
          ST_DEVADDR, ST_REGADDR, ST_WDATA: begin
            if (scl_rise_i) begin
              sh  <= {sh[BYTE_W-2:0], sda_i};
              cnt <= cnt + 1'b1;
              if (cnt == BIT_CW'(BYTE_W - 1)) full <= 1'b1;
            end else if (scl_fall_i && full) begin
              full  <= 1'b0;
              cnt   <= '0;
              state <= ST_ACK;
              if (state == ST_DEVADDR) begin
                if (sh[BYTE_W-1:1] == {DEV_HI, strap_i}) begin
                  sda_low_o <= 1'b1;
                  after_ack <= sh[0] ? ST_RDATA : ST_REGADDR;
                end else begin
                  state <= ST_IGNORE;
                end
              end else if (state == ST_REGADDR) begin
                if (sh <= BYTE_W'(TOP_REG)) begin
                  ptr       <= sh[ADDR_W-1:0];
                  sda_low_o <= 1'b1;
                  after_ack <= ST_WDATA;
                end else begin
                  state <= ST_IGNORE;
                end
              end else begin
                wr_en_o   <= 1'b1;
                wr_addr_o <= ptr;
                wr_data_o <= sh;
                ptr       <= sat_inc(ptr);
                sda_low_o <= 1'b1;
                after_ack <= ST_WDATA;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              state <= after_ack;
              if (after_ack == ST_RDATA) begin
                tx        <= rd_data_i[BYTE_W-2:0];
                sda_low_o <= ~rd_data_i[BYTE_W-1];
                ptr       <= sat_inc(ptr);
                cnt       <= '0;
              end else begin
                sda_low_o <= 1'b0;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise_i) begin
              cnt <= cnt + 1'b1;
              if (cnt == BIT_CW'(BYTE_W - 1)) full <= 1'b1;
            end else if (scl_fall_i) begin
              if (full) begin
                full      <= 1'b0;
                sda_low_o <= 1'b0;
                state     <= ST_RACK;
              end else begin
                sda_low_o <= ~tx[BYTE_W-2];
                tx        <= {tx[BYTE_W-3:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              more <= ~sda_i;
            end else if (scl_fall_i) begin
              if (more) begin
                tx        <= rd_data_i[BYTE_W-2:0];
                sda_low_o <= ~rd_data_i[BYTE_W-1];
                ptr       <= sat_inc(ptr);
                cnt       <= '0;
                state     <= ST_RDATA;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_o = ptr;
endmodule

// File: rtl/twi_regport.sv
module twi_regport
  import twi_pkg::*;
#(
  parameter int         NUM_REGS    = 26,
  parameter logic [5:0] DEV_ADDR_HI = 6'b100110,
  localparam int        ADDR_W      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_low_o,
  input  logic              addr_strap_i,
  input  logic [ADDR_W-1:0] host_raddr_i,
  output logic [BYTE_W-1:0] host_rdata_o
);
  localparam int TOP_REG = NUM_REGS - 1;

  logic              ev_rise, ev_fall, ev_start, ev_stop;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, ptr;
  logic [BYTE_W-1:0] wr_data, ptr_data;

  twi_bus_events u_events (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (ev_rise),
    .scl_fall_o (ev_fall),
    .start_o    (ev_start),
    .stop_o     (ev_stop)
  );

  twi_slave_engine #(
    .TOP_REG (TOP_REG),
    .ADDR_W  (ADDR_W),
    .DEV_HI  (DEV_ADDR_HI)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_rise_i (ev_rise),
    .scl_fall_i (ev_fall),
    .start_i    (ev_start),
    .stop_i     (ev_stop),
    .sda_i      (sda_i),
    .strap_i    (addr_strap_i),
    .rd_data_i  (ptr_data),
    .sda_low_o  (sda_pull_low_o),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .ptr_o      (ptr)
  );

  twi_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (BYTE_W),
    .ADDR_W   (ADDR_W)
  ) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .rd_addr_a_i (ptr),
    .rd_data_a_o (ptr_data),
    .rd_addr_b_i (host_raddr_i),
    .rd_data_b_o (host_rdata_o)
  );
endmodule

// File: rtl/twi_regport_chk.sv
module twi_regport_chk #(
  parameter int TOP_REG = 25,
  parameter int ADDR_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_low,
  input logic              start,
  input logic              stop,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] ptr
);
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= ADDR_W'(TOP_REG)); // R5
  AST_WR_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_addr <= ADDR_W'(TOP_REG)); // R6
  AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low) |-> !scl_i); // R10
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sda_low); // R1
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !sda_low); // R9
endmodule

bind twi_regport twi_regport_chk #(
  .TOP_REG (NUM_REGS - 1),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_i   (scl_i),
  .sda_low (sda_pull_low_o),
  .start   (ev_start),
  .stop    (ev_stop),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .ptr     (ptr)
);

// File: tb/twi_regport_tb.sv
module twi_regport_tb;
  localparam int NREG = 26;
  localparam int TOPR = NREG - 1;
  localparam int Q    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_low, sda_bus;
  logic [4:0] h_addr = '0;
  logic [7:0] h_data;

  int errors = 0, checks = 0, r10_viol = 0;
  logic [7:0] exp_reg [NREG];
  int exp_ptr = 0;
  logic [7:0] wbuf [8];

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~sda_low;

  twi_regport u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .scl_i          (scl_m),
    .sda_i          (sda_bus),
    .sda_pull_low_o (sda_low),
    .addr_strap_i   (strap),
    .host_raddr_i   (h_addr),
    .host_rdata_o   (h_data)
  );

  // R10 monitor: pull-low output must not move while SCL stays high
  logic prev_low = 1'b0, prev_scl = 1'b1;
  always @(posedge clk) begin
    if (rst_n && sda_low != prev_low && scl_m && prev_scl) r10_viol++;
    prev_low <= sda_low;
    prev_scl <= scl_m;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  function automatic int sat(input int p);
    return (p == TOPR) ? p : p + 1;
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b0; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b1; waitq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; waitq();
      scl_m = 1'b1; waitq();
      scl_m = 1'b0;
    end
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    ack = ~sda_bus;
    scl_m = 1'b0; waitq();
  endtask

  task automatic recv_byte(input bit m_ack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      waitq();
      scl_m = 1'b1; waitq();
      b = {b[6:0], sda_bus};
      scl_m = 1'b0;
    end
    sda_m = ~m_ack; waitq();
    scl_m = 1'b1; waitq();
    scl_m = 1'b0; waitq();
    sda_m = 1'b1;
  endtask

  // pointer write then n data bytes from wbuf; ok says whether acks are expected
  task automatic wr_burst(input logic [6:0] dev, input bit dev_ok, input int base,
                          input int n, input bit end_stop, input string tag);
    bit a;
    bit base_ok = (base <= TOPR);
    bus_start();
    send_byte({dev, 1'b0}, a);
    chk({tag, " device ack"}, a, dev_ok);
    send_byte(8'(base), a);
    chk({tag, " pointer ack"}, a, dev_ok && base_ok);
    if (dev_ok && base_ok) exp_ptr = base;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a);
      chk({tag, " data ack"}, a, dev_ok && base_ok);
      if (dev_ok && base_ok) begin
        exp_reg[exp_ptr] = wbuf[i];
        exp_ptr = sat(exp_ptr);
      end
    end
    if (end_stop) bus_stop();
  endtask

  task automatic rd_burst(input logic [6:0] dev, input int n, input string tag);
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte({dev, 1'b1}, a);
    chk({tag, " read device ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk({tag, " read data"}, b, exp_reg[exp_ptr]);
      exp_ptr = sat(exp_ptr);
    end
    bus_stop();
  endtask

  task automatic chk_local(input string tag);
    for (int i = 0; i < NREG; i++) begin
      @(negedge clk) h_addr = 5'(i);
      @(negedge clk) chk(tag, h_data, exp_reg[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] b;
    void'($urandom(32'd4242));
    for (int i = 0; i < NREG; i++) exp_reg[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 idle release", sda_low, 0);

    // R11: reset contents and pointer 0 (read starts at register 0)
    chk_local("R11 reset register / R12 local port");
    rd_burst(7'h4C, 2, "R11 pointer at reset");

    // R2 / R4 / R12: single write with strap 0
    wbuf[0] = 8'hA5;
    wr_burst(7'h4C, 1, 3, 1, 1, "R2 R4 single write");
    chk_local("R4 R12 after single write");

    // R2 / R3: strap 1 changes the address
    strap = 1'b1;
    wbuf[0] = 8'h3C; wbuf[1] = 8'h77;
    wr_burst(7'h4C, 0, 5, 2, 1, "R3 mismatch with strap 1");
    chk_local("R3 nothing written");
    wr_burst(7'h4D, 1, 5, 2, 1, "R2 strap 1 address");
    chk_local("R4 two-byte write");
    strap = 1'b0;
    wr_burst(7'h4D, 0, 1, 2, 1, "R3 mismatch with strap 0");
    chk_local("R3 nothing written again");

    // R6: pointer above top refused
    wbuf[0] = 8'hEE;
    wr_burst(7'h4C, 1, TOPR + 1, 2, 1, "R6 pointer 0x1A");
    chk_local("R6 no register changed");

    // R5: saturation on writes
    for (int i = 0; i < 5; i++) wbuf[i] = 8'h10 + 8'(i);
    wr_burst(7'h4C, 1, TOPR - 2, 5, 1, "R5 burst over top");
    chk_local("R5 top register holds last byte");

    // R9 / R7: pointer write then repeated start read, saturated read
    wr_burst(7'h4C, 1, TOPR - 1, 0, 0, "R9 pointer only");
    rd_burst(7'h4C, 4, "R9 R7 repeated-start read over top");

    // R8: master nack ends the read; following clocks see no pull
    wr_burst(7'h4C, 1, 3, 0, 0, "R8 pointer");
    bus_start();
    send_byte({7'h4C, 1'b1}, a);
    chk("R8 read device ack", a, 1);
    recv_byte(0, b);
    chk("R8 read data", b, exp_reg[exp_ptr]);
    exp_ptr = sat(exp_ptr);
    chk("R8 released after nack", sda_low, 0);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; waitq();
      scl_m = 1'b1; waitq();
      chk("R8 no bit driven after nack", sda_low, 0);
      scl_m = 1'b0;
    end
    waitq();
    bus_stop();

    // R1: after a stop, a byte with no start is ignored
    send_byte({7'h4C, 1'b0}, a);
    chk("R1 no ack without start", a, 0);
    send_byte(8'h02, a);
    chk("R1 still ignored", a, 0);
    bus_stop();
    chk_local("R1 nothing written");

    // random bursts with read-back
    for (int t = 0; t < 30; t++) begin
      int base = int'($urandom_range(TOPR, 0));
      int n = int'($urandom_range(4, 1));
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wr_burst(7'h4C, 1, base, n, 1, "R4 R5 random write");
      wr_burst(7'h4C, 1, base, 0, 0, "R9 random pointer");
      rd_burst(7'h4C, n + 1, "R7 random read-back");
    end
    chk_local("R12 final contents");
    chk("R10 pull changes only with SCL low", r10_viol, 0);

    summary();
    $finish;
  end
endmodule